// File: doc/BRIEF.md
# Parallel SAR Converter Host Controller

This block runs a 16-bit successive-approximation converter that has a parallel data bus. It drives the converter's active-low select, its read/convert strobe and its byte-select line, and it watches the converter's busy flag. It starts conversions at a rate the host sets and reads each result either as one 16-bit word or as two bytes over an 8-bit bus. It then hands each result to a valid/ready stream, extended to the stream width either with the sign bit or with zeros.

After reset the controller first sends a terminating pulse on the strobe, so that any conversion left running is cut short. It then waits one full acquisition interval before the first real start. Every interval is a parameter counted in system-clock cycles. If the busy flag does not fall after a start, or does not come back within the conversion timeout, the controller flags an error and runs the terminate sequence again.

Top module: `sarpar_host`

## Requirements
- R1: While reset is held, the select and strobe outputs are high, byte-select is low, the stream valid is low, the error output is low and the overrun count is zero.
- R2: After reset, the first strobe pulse is a terminating pulse with select low, lasting T_PULSE cycles. The strobe then stays high for at least T_CYCLE cycles before the next strobe falling edge.
- R3: Select is low for at least T_SU cycles before each strobe falling edge. Every strobe low pulse lasts exactly T_PULSE cycles, and the strobe is never low while select is high.
- R4: While enabled, consecutive conversion starts (strobe falling edges) are spaced by max(period_cyc, T_CYCLE) cycles, provided the converter finishes in time.
- R5: In word mode (byte_mode=0), once busy returns high the controller drives select low with the strobe high and byte-select low. It captures all 16 bus bits after T_EN cycles.
- R6: In byte mode (byte_mode=1), byte-select low returns result bits 15..8 on adc_data[7:0] and is sampled after T_EN cycles. Then byte-select goes high for T_BYTE cycles and returns bits 7..0. Byte-select is high only while select is low, and adc_data[15:8] is ignored in this mode.
- R7: The result is two's complement (0x8000 negative full scale, 0x7FFF positive full scale). With sext_en=1, m_data bits above bit 15 copy bit 15; with sext_en=0 they are zero.
- R8: Once m_valid is high it stays high, with its data, until a cycle in which m_ready is high. It drops in the cycle after that acceptance unless a new result arrives.
- R9: A new result that arrives while the previous one is still unaccepted replaces it on m_data, and overrun_cnt increments by one, saturating.
- R10: If busy has not fallen within T_BFALL cycles after the strobe pulse ends, err pulses for one cycle, no result is produced, and the terminate sequence restarts.
- R11: If busy has fallen but does not rise within T_CTO cycles, err pulses for one cycle and the terminate sequence restarts. Normal results resume afterwards.
- R12: While en is low, no new conversion is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Allows new conversion starts |
| byte_mode | input | 1 | 1: two-byte read on adc_data[7:0]; 0: 16-bit read |
| sext_en | input | 1 | 1: sign-extend result to OUT_W; 0: zero-extend |
| period_cyc | input | PER_W | Requested start-to-start period in clock cycles (floored at T_CYCLE) |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_rc_n | output | 1 | Read/convert strobe: low starts or terminates, high reads |
| adc_byte_sel | output | 1 | Byte select: 0 high byte, 1 low byte |
| adc_busy | input | 1 | Converter busy flag, low while converting (asynchronous) |
| adc_data | input | 16 | Converter data bus |
| m_valid | output | 1 | Stream result valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | OUT_W | Extended conversion result |
| err | output | 1 | One-cycle pulse on a busy timeout |
| overrun_cnt | output | CNT_W | Saturating count of overwritten results |

## Verification
The hardest states to reach are the two busy timeouts, because a working converter never produces them. The bench's converter model has a mode in which it ignores starts and a mode in which it never finishes. The bench switches the model into each mode, watches for the error pulse and the terminate pulse that follows, and then restores the model to confirm that a correct result comes out again. The overrun case is reached by holding m_ready low across two complete conversions.

// File: rtl/sarpar_pkg.sv
`timescale 1ns/1ps
package sarpar_pkg;

    localparam int RAW_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_BOOT,
        S_ABT_SU,
        S_ABT_LO,
        S_ABT_ACQ,
        S_IDLE,
        S_SETUP,
        S_CONV,
        S_WLO,
        S_WHI,
        S_RDH,
        S_RDL,
        S_REL
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic rc_n;
        logic bsel;
    } pins_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Converter pin levels owned by each sequencer state.
    function automatic pins_t pins_of(input seq_state_e s);
        pins_t p;
        p.cs_n = 1'b1;
        p.rc_n = 1'b1;
        p.bsel = 1'b0;
        case (s)
            S_ABT_SU, S_SETUP: p.cs_n = 1'b0;
            S_ABT_LO, S_CONV: begin
                p.cs_n = 1'b0;
                p.rc_n = 1'b0;
            end
            S_RDH: p.cs_n = 1'b0;
            S_RDL: begin
                p.cs_n = 1'b0;
                p.bsel = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sarpar_sync.sv
`timescale 1ns/1ps
module sarpar_sync #(
    parameter int   STAGES = 2,
    parameter logic RST_V  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= {STAGES{RST_V}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/sarpar_seq.sv
`timescale 1ns/1ps
module sarpar_seq
    import sarpar_pkg::*;
#(
    parameter int PER_W   = 16,
    parameter int T_SU    = 2,
    parameter int T_PULSE = 8,
    parameter int T_EN    = 6,
    parameter int T_BYTE  = 6,
    parameter int T_REL   = 17,
    parameter int T_CYCLE = 800,
    parameter int T_BFALL = 6,
    parameter int T_CTO   = 1200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             byte_mode,
    input  logic [PER_W-1:0] period_cyc,
    input  logic             busy_s,
    input  logic [RAW_W-1:0] bus_in,
    output pins_t            pins,
    output logic             push,
    output logic [RAW_W-1:0] push_word,
    output logic             err
);
    localparam int TMAX = imax(imax(imax(T_SU, T_PULSE), imax(T_EN, T_BYTE)),
                               imax(imax(T_REL, T_CYCLE), imax(T_BFALL, T_CTO)));
    localparam int CW   = $clog2(TMAX + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CW-1:0]     cnt;
        logic [PER_W-1:0]  gap;
        logic [BYTE_W-1:0] hi;
        pins_t             pins;
        logic              push;
        logic [RAW_W-1:0]  word;
        logic              err;
    } seq_regs_t;

    seq_regs_t d, q;
    logic [PER_W-1:0] need;
    logic             gap_ok;

    assign need   = (period_cyc > PER_W'(T_CYCLE)) ? period_cyc : PER_W'(T_CYCLE);
    assign gap_ok = ({1'b0, q.gap} + (PER_W+1)'(1)) >= {1'b0, need};

    always_comb begin
        d      = q;
        d.push = 1'b0;
        d.err  = 1'b0;
        d.gap  = (&q.gap) ? q.gap : q.gap + 1'b1;
        case (q.st)
            S_BOOT:   d.st = S_ABT_SU;
            S_ABT_SU: if (q.cnt == CW'(T_SU - 1)) d.st = S_ABT_LO;
            S_ABT_LO: if (q.cnt == CW'(T_PULSE - 1)) d.st = S_ABT_ACQ;
            S_ABT_ACQ: if (q.cnt == CW'(T_CYCLE - 1)) begin
                d.st  = S_IDLE;
                d.gap = '1;
            end
            S_IDLE: if (en && gap_ok) begin
                d.st  = S_SETUP;
                d.gap = '0;
            end
            S_SETUP: if (q.cnt == CW'(T_SU - 1)) d.st = S_CONV;
            S_CONV:  if (q.cnt == CW'(T_PULSE - 1)) d.st = S_WLO;
            S_WLO: begin
                if (!busy_s) begin
                    d.st = S_WHI;
                end else if (q.cnt >= CW'(T_BFALL - 1)) begin
                    d.st  = S_ABT_SU;
                    d.err = 1'b1;
                end
            end
            S_WHI: begin
                if (busy_s) begin
                    d.st = S_RDH;
                end else if (q.cnt >= CW'(T_CTO - 1)) begin
                    d.st  = S_ABT_SU;
                    d.err = 1'b1;
                end
            end
            S_RDH: if (q.cnt == CW'(T_EN - 1)) begin
                if (byte_mode) begin
                    d.hi = bus_in[BYTE_W-1:0];
                    d.st = S_RDL;
                end else begin
                    d.word = bus_in;
                    d.push = 1'b1;
                    d.st   = S_REL;
                end
            end
            S_RDL: if (q.cnt == CW'(T_BYTE - 1)) begin
                d.word = {q.hi, bus_in[BYTE_W-1:0]};
                d.push = 1'b1;
                d.st   = S_REL;
            end
            S_REL: if (q.cnt == CW'(T_REL - 1)) d.st = S_IDLE;
            default: d.st = S_BOOT;
        endcase
        if (d.st != q.st)      d.cnt = '0;
        else if (!(&q.cnt))    d.cnt = q.cnt + 1'b1;
        d.pins = pins_of(d.st);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= S_BOOT;
            q.cnt  <= '0;
            q.gap  <= '1;
            q.hi   <= '0;
            q.pins <= pins_of(S_BOOT);
            q.push <= 1'b0;
            q.word <= '0;
            q.err  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pins      = q.pins;
    assign push      = q.push;
    assign push_word = q.word;
    assign err       = q.err;
endmodule

// File: rtl/sarpar_out.sv
`timescale 1ns/1ps
module sarpar_out
    import sarpar_pkg::*;
#(
    parameter int OUT_W = 24,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [RAW_W-1:0] word,
    input  logic             sext_en,
    input  logic             m_ready,
    output logic             m_valid,
    output logic [OUT_W-1:0] m_data,
    output logic [CNT_W-1:0] ovr_cnt
);
    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] data;
        logic [CNT_W-1:0] ovr;
    } out_regs_t;

    out_regs_t d, q;
    logic [OUT_W-1:0] ext;

    generate
        if (OUT_W > RAW_W) begin : g_wide
            assign ext = {{(OUT_W-RAW_W){sext_en & word[RAW_W-1]}}, word};
        end else begin : g_same
            logic unused_sx;
            assign unused_sx = sext_en;
            assign ext       = word[OUT_W-1:0];
        end
    endgenerate

    always_comb begin
        d = q;
        if (q.vld && m_ready) d.vld = 1'b0;
        if (push) begin
            if (q.vld && !m_ready && !(&q.ovr)) d.ovr = q.ovr + 1'b1;
            d.vld  = 1'b1;
            d.data = ext;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.vld  <= 1'b0;
            q.data <= '0;
            q.ovr  <= '0;
        end else begin
            q <= d;
        end
    end

    assign m_valid = q.vld;
    assign m_data  = q.data;
    assign ovr_cnt = q.ovr;
endmodule

// File: rtl/sarpar_host.sv
`timescale 1ns/1ps
module sarpar_host
    import sarpar_pkg::*;
#(
    parameter int PER_W   = 16,
    parameter int OUT_W   = 24,
    parameter int CNT_W   = 8,
    parameter int T_SU    = 2,
    parameter int T_PULSE = 8,
    parameter int T_EN    = 6,
    parameter int T_BYTE  = 6,
    parameter int T_REL   = 17,
    parameter int T_CYCLE = 800,
    parameter int T_BFALL = 6,
    parameter int T_CTO   = 1200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             byte_mode,
    input  logic             sext_en,
    input  logic [PER_W-1:0] period_cyc,
    output logic             adc_cs_n,
    output logic             adc_rc_n,
    output logic             adc_byte_sel,
    input  logic             adc_busy,
    input  logic [15:0]      adc_data,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [OUT_W-1:0] m_data,
    output logic             err,
    output logic [CNT_W-1:0] overrun_cnt
);
    logic             busy_s;
    pins_t            pins;
    logic             push;
    logic [RAW_W-1:0] push_word;

    sarpar_sync #(.STAGES(2), .RST_V(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (adc_busy),
        .dout (busy_s)
    );

    sarpar_seq #(
        .PER_W(PER_W), .T_SU(T_SU), .T_PULSE(T_PULSE), .T_EN(T_EN),
        .T_BYTE(T_BYTE), .T_REL(T_REL), .T_CYCLE(T_CYCLE),
        .T_BFALL(T_BFALL), .T_CTO(T_CTO)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .byte_mode (byte_mode),
        .period_cyc(period_cyc),
        .busy_s    (busy_s),
        .bus_in    (adc_data),
        .pins      (pins),
        .push      (push),
        .push_word (push_word),
        .err       (err)
    );

    sarpar_out #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .word   (push_word),
        .sext_en(sext_en),
        .m_ready(m_ready),
        .m_valid(m_valid),
        .m_data (m_data),
        .ovr_cnt(overrun_cnt)
    );

    assign adc_cs_n     = pins.cs_n;
    assign adc_rc_n     = pins.rc_n;
    assign adc_byte_sel = pins.bsel;
endmodule

// File: rtl/sarpar_host_chk.sv
`timescale 1ns/1ps
module sarpar_host_chk #(
    parameter int CNT_W   = 8,
    parameter int T_SU    = 2,
    parameter int T_PULSE = 8,
    parameter int T_CYCLE = 800
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             rc_n,
    input logic             bsel,
    input logic             m_valid,
    input logic             m_ready,
    input logic             err,
    input logic [CNT_W-1:0] ovr_cnt
);
    logic [31:0] cs_run, lo_run, since;
    logic        rc_prev, pend, fell_now;

    assign fell_now = rc_prev && !rc_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_run  <= '0;
            lo_run  <= '0;
            since   <= 32'hFFFF_FFFF;
            rc_prev <= 1'b1;
            pend    <= 1'b1;
        end else begin
            rc_prev <= rc_n;
            cs_run  <= cs_n ? '0 : ((&cs_run) ? cs_run : cs_run + 1);
            lo_run  <= rc_n ? '0 : ((&lo_run) ? lo_run : lo_run + 1);
            since   <= fell_now ? 32'd1 : ((&since) ? since : since + 1);
            pend    <= err ? 1'b1 : (fell_now ? 1'b0 : pend);
        end
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (cs_n && rc_n && !bsel && !m_valid && !err && ovr_cnt == '0));
    // R3
    a_r3_cs_leads: assert property (@(posedge clk) disable iff (!rst_n)
        fell_now |-> (!cs_n && cs_run >= 32'(T_SU)));
    // R2, R3
    a_r3_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_n && !rc_prev) |-> (lo_run == 32'(T_PULSE)));
    // R3
    a_r3_rc_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_n |-> !cs_n);
    // R4
    a_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (fell_now && !pend) |-> (since >= 32'(T_CYCLE)));
    // R6
    a_r6_bsel_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        bsel |-> (!cs_n && rc_n));
    // R8
    a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> m_valid);
    // R9
    a_r9_ovr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ovr_cnt) |-> (ovr_cnt == $past(ovr_cnt) + 1'b1 && m_valid));
    // R10, R11
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
endmodule

bind sarpar_host sarpar_host_chk #(
    .CNT_W(CNT_W), .T_SU(T_SU), .T_PULSE(T_PULSE), .T_CYCLE(T_CYCLE)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (adc_cs_n),
    .rc_n   (adc_rc_n),
    .bsel   (adc_byte_sel),
    .m_valid(m_valid),
    .m_ready(m_ready),
    .err    (err),
    .ovr_cnt(overrun_cnt)
);

// File: tb/sarpar_host_test.sv
`timescale 1ns/1ps
module sarpar_host_test;
    localparam int TSU = 2, TPL = 8, TEN = 6, TBY = 6, TRL = 17;
    localparam int TCY = 100, TBF = 4, TTO = 60, CONV = 20;
    localparam int NV = 8;
    // fields: byte_mode, sext_en, period[15:0], word[15:0], expected[23:0]
    localparam logic [57:0] VEC [NV] = '{
        {1'b0, 1'b1, 16'd0,   16'h7FFF, 24'h007FFF},
        {1'b0, 1'b1, 16'd0,   16'h8000, 24'hFF8000},
        {1'b0, 1'b0, 16'd0,   16'h8000, 24'h008000},
        {1'b1, 1'b1, 16'd0,   16'h1234, 24'h001234},
        {1'b1, 1'b1, 16'd150, 16'hFFFF, 24'hFFFFFF},
        {1'b1, 1'b0, 16'd150, 16'hA5C3, 24'h00A5C3},
        {1'b0, 1'b1, 16'd40,  16'h0000, 24'h000000},
        {1'b1, 1'b1, 16'd0,   16'h8001, 24'hFF8001}
    };

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, byte_mode = 1'b0, sext_en = 1'b0, m_ready = 1'b0;
    logic [15:0] period = '0;
    logic cs_n, rc_n, bsel, m_valid, err;
    logic [23:0] m_data;
    logic [7:0]  ovr;
    logic [15:0] adc_data;
    logic        adc_busy;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sarpar_host #(
        .PER_W(16), .OUT_W(24), .CNT_W(8), .T_SU(TSU), .T_PULSE(TPL), .T_EN(TEN),
        .T_BYTE(TBY), .T_REL(TRL), .T_CYCLE(TCY), .T_BFALL(TBF), .T_CTO(TTO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .byte_mode(byte_mode), .sext_en(sext_en),
        .period_cyc(period), .adc_cs_n(cs_n), .adc_rc_n(rc_n), .adc_byte_sel(bsel),
        .adc_busy(adc_busy), .adc_data(adc_data), .m_valid(m_valid), .m_ready(m_ready),
        .m_data(m_data), .err(err), .overrun_cnt(ovr)
    );

    // Converter model: mode 0 normal, 1 ignores starts, 2 never finishes.
    logic        mdl_busy = 1'b1, rc_prev = 1'b1;
    int          mdl_cnt = 0, mdl_mode = 0;
    logic [15:0] mdl_word = 16'h0000, mdl_next = 16'h0000;
    int fall_t [64], rise_t [64];
    int nf = 0, nr = 0, nerr = 0, err_t = 0, cs_run = 0, lo_run = 0;
    int min_setup = 999, lo_min = 999, lo_max = 0;

    assign adc_busy = mdl_busy;
    always_comb begin
        if (!cs_n && rc_n)
            adc_data = byte_mode ? {8'hA5, (bsel ? mdl_word[7:0] : mdl_word[15:8])} : mdl_word;
        else
            adc_data = 16'hDEAD;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rc_prev && !rc_n && !cs_n) begin
                if (nf < 64) fall_t[nf] = cyc;
                nf++;
                if (cs_run < min_setup) min_setup = cs_run;
                if (mdl_busy) begin
                    if (mdl_mode != 1) begin mdl_busy = 1'b0; mdl_cnt = CONV; end
                end else begin
                    mdl_busy = 1'b1;
                end
            end else if (!mdl_busy && mdl_cnt > 0) begin
                mdl_cnt--;
                if (mdl_cnt == 0 && mdl_mode != 2) begin
                    mdl_busy = 1'b1;
                    mdl_word = mdl_next;
                end
            end
            if (!rc_prev && rc_n) begin
                if (nr < 64) rise_t[nr] = cyc;
                nr++;
                if (lo_run < lo_min) lo_min = lo_run;
                if (lo_run > lo_max) lo_max = lo_run;
            end
            lo_run = rc_n ? 0 : lo_run + 1;
            cs_run = (!cs_n && rc_n) ? cs_run + 1 : 0;
            if (err) begin nerr++; err_t = cyc; end
            rc_prev = rc_n;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_valid(input int lim, output bit ok);
        int n = 0;
        while (!m_valid && n < lim) begin @(negedge clk); n++; end
        ok = m_valid;
    endtask

    task automatic load_vec(input int k);
        byte_mode = VEC[k][57];
        sext_en   = VEC[k][56];
        period    = VEC[k][55:40];
        mdl_next  = VEC[k][39:24];
    endtask

    function automatic int spacing_of(input logic [15:0] p);
        return (int'(p) > TCY) ? int'(p) : TCY;
    endfunction

    initial begin
        bit ok;
        int n0, e0, lim, exp_sp;
        load_vec(0);
        en = 1'b1;
        repeat (3) @(negedge clk);
        // R1: idle levels while reset is held
        check(cs_n && rc_n && !bsel, "R1 pins", {cs_n, rc_n, bsel}, 3'b110);
        check(!m_valid && !err && ovr == 0, "R1 stream", {m_valid, err, ovr}, 0);
        rst_n = 1'b1;

        // Table walk: R4 R5 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            exp_sp = spacing_of(VEC[k][55:40]);
            wait_valid(600, ok);
            check(ok, "R5 result arrives", ok, 1);
            check(m_data == VEC[k][23:0], VEC[k][57] ? "R6 R7 byte data" : "R5 R7 word data",
                  m_data, VEC[k][23:0]);
            if (k > 0 && nf >= 2)
                check(fall_t[nf-1] - fall_t[nf-2] == exp_sp, "R4 start spacing",
                      fall_t[nf-1] - fall_t[nf-2], exp_sp);
            if (k + 1 < NV) load_vec(k + 1);
            else en = 1'b0;
            m_ready = 1'b1;
            @(negedge clk);
            m_ready = 1'b0;
            check(!m_valid, "R8 drop after accept", m_valid, 0);
        end

        // R2: start-up terminate pulse and acquisition wait
        check(rise_t[0] - fall_t[0] == TPL, "R2 terminate pulse", rise_t[0] - fall_t[0], TPL);
        check(fall_t[1] - rise_t[0] >= TCY, "R2 acquisition wait", fall_t[1] - rise_t[0], TCY);
        // R3: setup and pulse width on every start
        check(min_setup >= TSU, "R3 select setup", min_setup, TSU);
        check(lo_min == TPL && lo_max == TPL, "R3 pulse width", {lo_min, lo_max}, TPL);

        // R12: no starts while disabled
        n0 = nf;
        repeat (300) @(negedge clk);
        check(nf == n0, "R12 no start when disabled", nf, n0);

        // R8 R9: overrun while consumer stalls
        byte_mode = 1'b0; sext_en = 1'b1; period = 16'd0; mdl_next = 16'h0102;
        en = 1'b1;
        wait_valid(600, ok);
        check(ok && m_data == 24'h000102, "R9 first result", m_data, 24'h000102);
        mdl_next = 16'hFEDC;
        lim = 0; ok = 1'b1;
        while (ovr == 0 && lim < 400) begin
            @(negedge clk); lim++;
            if (!m_valid) ok = 1'b0;
        end
        en = 1'b0;
        check(ok, "R8 valid held while stalled", ok, 1);
        check(ovr == 8'd1, "R9 overrun count", ovr, 1);
        check(m_data == 24'hFFFEDC, "R9 overwrite", m_data, 24'hFFFEDC);
        m_ready = 1'b1;
        @(negedge clk);
        m_ready = 1'b0;
        check(!m_valid, "R8 drop after accept", m_valid, 0);

        // R10: busy never falls
        mdl_mode = 1; e0 = nerr; en = 1'b1;
        lim = 0;
        while (nerr == e0 && lim < 400) begin @(negedge clk); lim++; end
        mdl_mode = 0;
        check(nerr == e0 + 1, "R10 error raised", nerr - e0, 1);
        check(err_t - fall_t[nf-1] <= TPL + TBF + 4, "R10 error latency", err_t - fall_t[nf-1], TPL + TBF + 4);
        n0 = nf;
        repeat (20) @(negedge clk);
        check(nf == n0 + 1, "R10 terminate rerun", nf - n0, 1);
        check(!m_valid, "R10 no result", m_valid, 0);

        // R11: busy never rises
        wait (mdl_busy == 1'b1);
        mdl_mode = 2; e0 = nerr;
        lim = 0;
        while (nerr == e0 && lim < 600) begin @(negedge clk); lim++; end
        mdl_mode = 0;
        check(nerr == e0 + 1, "R11 error raised", nerr - e0, 1);
        check(err_t - fall_t[nf-1] >= TTO && err_t - fall_t[nf-1] <= TTO + TPL + 12,
              "R11 timeout window", err_t - fall_t[nf-1], TTO);
        mdl_next = 16'h4321;
        wait_valid(800, ok);
        check(ok && m_data == 24'h004321, "R11 recovery result", m_data, 24'h004321);
        en = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule